// File: doc/BRIEF.md
# SPI EEPROM Page-Write Sequencer

This block stores a run of 16-bit words into a serial EEPROM reached over a four-wire SPI link in clock mode 0. A request gives a starting word offset and a word count. The block first checks the request against the device size. It then takes the words one at a time through a valid/ready input and writes them to the device, one page at a time.

Each page follows the same steps. The block polls the device status register until the device reports that it is not busy. It then sends a write-enable command in its own frame. Next it opens a write frame that holds the write opcode, the byte address and the data words. The frame closes after the last word of the run, or earlier when the next byte address starts a new page. Any words left over go into a fresh page with a new status poll.

Byte addresses are twice the word offset. Each word leaves low byte first. On parts with eight address bits, the ninth address bit travels inside the opcode. When the request finishes, the block gives a one-cycle completion pulse. An error flag, valid with that pulse, reports a rejected request or a device that stayed busy too long.

Top module: `spi_eeprom_page_writer`

## Requirements
- R1: A request is rejected when the word count is zero, the offset is at or beyond DEV_WORDS, or offset plus count exceeds DEV_WORDS. On rejection, `done` rises in the cycle after `start`, with `err` high, and `cs_n` never leaves its high (deselected) level.
- R2: Every field is shifted most significant bit first. `mosi` is set while `sclk` is low and stays stable while `sclk` is high. `mosi` is low after each field and during every read. `sclk` and `mosi` are both low whenever `cs_n` is high.
- R3: Before each page, the block sends the status-read opcode 0x05 and shifts in 8 status bits, sampled while `sclk` is high. It proceeds only when status bit 0 is clear; the other status bits are ignored. Each retry is separated from the previous frame by a `cs_n` high pulse.
- R4: If status bit 0 is still set after POLL_MAX consecutive polls, the block raises `cs_n`, ends with `done` and `err` high, and accepts no words.
- R5: After a ready status, a frame holding only the write-enable opcode 0x06 precedes each write frame.
- R6: A write frame starts with opcode 0x02 and then ADDR_BITS bits of byte address, equal to (2 × word offset) mod 2^ADDR_BITS. When ADDR_BITS is 8 and the page's first word offset is 128 or more, opcode bit 3 is also set (opcode 0x0A).
- R7: Each data word goes out as 16 bits, with its low byte (bits 7:0) first and its high byte second.
- R8: A write frame ends after the word whose next byte address is a multiple of PAGE_BYTES, or after the last word. Remaining words continue in a new poll, write-enable and write sequence starting at the next offset.
- R9: `word_ready` is high only while the block waits for the next data word inside a write frame. Exactly one word is consumed per cycle with `word_valid` and `word_ready` both high. A successful run consumes exactly the word count.
- R10: `done` is a single-cycle pulse per accepted `start`. `err` is low with it after a successful run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| start_off | input | OFS_W | First word offset of the run |
| word_cnt | input | OFS_W+1 | Number of words in the run |
| word_data | input | 16 | Data word offered to the block |
| word_valid | input | 1 | `word_data` is valid |
| word_ready | output | 1 | Block takes `word_data` this cycle if valid |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with `done` |
| cs_n | output | 1 | Device chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data toward the device |
| miso | input | 1 | Serial data from the device |

## Verification
The bench builds the block with 256 words, 8 address bits, 16-byte pages, a half-bit of 2 clocks and POLL_MAX of 4. This small page size lets a short run cross a page boundary. The 8-bit address width puts the opcode-embedded ninth address bit within reach at offsets 128 and above. The 256-word size makes the upper range edge cheap to hit. The device model can hold its busy bit for a chosen number of polls, which drives both the retry path and the timeout path. Stalls on the word input test that framing does not depend on how fast words arrive.

// File: rtl/spi_eew_pkg.sv
package spi_eew_pkg;

  localparam logic [7:0] OP_STATUS_RD = 8'h05;
  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_WR_DATA   = 8'h02;
  localparam logic [7:0] OP_HI_ADDR   = 8'h08;

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_POLL_OP, S_POLL_RX, S_GAP_HI, S_GAP_LO,
    S_WREN, S_WCMD, S_WADDR, S_WGET, S_WDATA, S_ENDPG, S_FIN
  } sew_state_t;

  // request lies fully inside the device
  function automatic logic req_in_range(input int unsigned off,
                                        input int unsigned cnt,
                                        input int unsigned dev_words);
    return (cnt != 0) && (off < dev_words) && (cnt <= dev_words - off);
  endfunction

  // true when word offset next_word starts a new page
  function automatic logic page_closes(input int unsigned next_word,
                                       input int unsigned page_bytes);
    return ((next_word * 2) % page_bytes) == 0;
  endfunction

  function automatic logic [15:0] swap_bytes(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  // byte address sent on the wire, truncated to the address field width
  function automatic logic [15:0] byte_addr(input int unsigned word_off,
                                            input int unsigned abits);
    int unsigned b;
    b = word_off * 2;
    if (abits < 16) b = b % (32'd1 << abits);
    return 16'(b);
  endfunction

  function automatic logic [7:0] write_opcode(input int unsigned word_off,
                                              input int unsigned abits);
    logic [7:0] op;
    op = OP_WR_DATA;
    if (abits == 8 && word_off >= 128) op = op | OP_HI_ADDR;
    return op;
  endfunction

endpackage

// File: rtl/spi_eew_half_timer.sv
module spi_eew_half_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  output logic expire
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  assign expire = en && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear || expire)  cnt <= '0;
    else if (en)               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_eew_shifter.sv
module spi_eew_shifter #(
  parameter int SH_W     = 16,
  parameter int RX_W     = 8,
  parameter int HALF_DIV = 2,
  localparam int NB_W    = $clog2(SH_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            rd_mode,
  input  logic [NB_W-1:0] nbits,
  input  logic [SH_W-1:0] tx,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic            fin,
  output logic [RX_W-1:0] rx
);
  logic [SH_W-1:0] sh;
  logic [SH_W-1:0] aligned;
  logic [NB_W-1:0] left;
  logic            busy;
  logic            hi;
  logic            rd;
  logic            half_up;

  spi_eew_half_timer #(.HALF_DIV(HALF_DIV)) u_half (
    .clk(clk), .rst_n(rst_n), .clear(go), .en(busy), .expire(half_up)
  );

  // first bit of the field moved to the top
  always_comb aligned = tx << (NB_W'(SH_W) - nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; left <= '0; busy <= 1'b0; hi <= 1'b0; rd <= 1'b0;
      sclk <= 1'b0; mosi <= 1'b0; fin <= 1'b0; rx <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        hi   <= 1'b0;
        sclk <= 1'b0;
        rd   <= rd_mode;
        left <= nbits;
        sh   <= aligned;
        rx   <= '0;
        mosi <= rd_mode ? 1'b0 : aligned[SH_W-1];
      end else if (busy && half_up) begin
        if (!hi) begin
          sclk <= 1'b1;
          hi   <= 1'b1;
        end else begin
          sclk <= 1'b0;
          hi   <= 1'b0;
          if (rd) rx <= {rx[RX_W-2:0], miso};
          sh   <= sh << 1;
          left <= left - 1'b1;
          if (left == NB_W'(1)) begin
            busy <= 1'b0;
            fin  <= 1'b1;
            mosi <= 1'b0;
          end else begin
            mosi <= rd ? 1'b0 : sh[SH_W-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_page_writer.sv
module spi_eeprom_page_writer
  import spi_eew_pkg::*;
#(
  parameter int DEV_WORDS  = 256,
  parameter int ADDR_BITS  = 8,
  parameter int OPC_W      = 8,
  parameter int PAGE_BYTES = 16,
  parameter int HALF_DIV   = 2,
  parameter int POLL_MAX   = 4,
  localparam int OFS_W     = $clog2(DEV_WORDS),
  localparam int CNT_W     = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OFS_W-1:0] start_off,
  input  logic [CNT_W-1:0] word_cnt,
  input  logic [15:0]      word_data,
  input  logic             word_valid,
  output logic             word_ready,
  output logic             done,
  output logic             err,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  localparam int SH_W = 16;
  localparam int RX_W = 8;
  localparam int NB_W = $clog2(SH_W + 1);
  localparam int RT_W = $clog2(POLL_MAX + 1);

  sew_state_t       state, gap_next;
  logic             cs_q, err_q, launched;
  logic [CNT_W-1:0] cur_off, remaining;
  logic [RT_W-1:0]  retries;
  logic [15:0]      word_q;

  logic             is_shift, sh_go, sh_rd, sh_fin;
  logic [NB_W-1:0]  sh_nb;
  logic [SH_W-1:0]  sh_tx;
  logic [RX_W-1:0]  sh_rx;
  logic             cs_wait, cs_half;
  logic             req_ok, last_of_page;

  // named events for the checker
  logic             ev_idle, ev_poll_done;
  logic [RX_W-1:0]  ev_status;

  assign ev_idle      = (state == S_IDLE);
  assign ev_poll_done = (state == S_POLL_RX) && sh_fin;
  assign ev_status    = sh_rx;

  assign req_ok       = req_in_range(int'(start_off), int'(word_cnt), DEV_WORDS);
  assign last_of_page = page_closes(int'(cur_off) + 1, PAGE_BYTES);

  assign is_shift = (state == S_POLL_OP) || (state == S_POLL_RX) || (state == S_WREN) ||
                    (state == S_WCMD) || (state == S_WADDR) || (state == S_WDATA);
  assign sh_go    = is_shift && !launched;
  assign cs_wait  = (state == S_SEL) || (state == S_GAP_HI) ||
                    (state == S_GAP_LO) || (state == S_ENDPG);

  always_comb begin
    sh_rd = 1'b0;
    sh_nb = '0;
    sh_tx = '0;
    case (state)
      S_POLL_OP: begin sh_nb = NB_W'(OPC_W); sh_tx = SH_W'(OP_STATUS_RD); end
      S_POLL_RX: begin sh_nb = NB_W'(RX_W); sh_rd = 1'b1; end
      S_WREN:    begin sh_nb = NB_W'(OPC_W); sh_tx = SH_W'(OP_WR_ENABLE); end
      S_WCMD:    begin
        sh_nb = NB_W'(OPC_W);
        sh_tx = SH_W'(write_opcode(int'(cur_off), ADDR_BITS));
      end
      S_WADDR:   begin
        sh_nb = NB_W'(ADDR_BITS);
        sh_tx = SH_W'(byte_addr(int'(cur_off), ADDR_BITS));
      end
      S_WDATA:   begin sh_nb = NB_W'(16); sh_tx = SH_W'(swap_bytes(word_q)); end
      default:   ;
    endcase
  end

  spi_eew_shifter #(.SH_W(SH_W), .RX_W(RX_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .rd_mode(sh_rd), .nbits(sh_nb),
    .tx(sh_tx), .miso(miso), .sclk(sclk), .mosi(mosi), .fin(sh_fin), .rx(sh_rx)
  );

  spi_eew_half_timer #(.HALF_DIV(HALF_DIV)) u_cs_time (
    .clk(clk), .rst_n(rst_n), .clear(!cs_wait), .en(cs_wait), .expire(cs_half)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      gap_next  <= S_IDLE;
      cs_q      <= 1'b1;
      err_q     <= 1'b0;
      launched  <= 1'b0;
      cur_off   <= '0;
      remaining <= '0;
      retries   <= '0;
      word_q    <= '0;
    end else begin
      if (sh_go) launched <= 1'b1;
      case (state)
        S_IDLE: if (start) begin
          cur_off   <= CNT_W'(start_off);
          remaining <= word_cnt;
          retries   <= '0;
          if (req_ok) begin
            err_q <= 1'b0;
            cs_q  <= 1'b0;
            state <= S_SEL;
          end else begin
            err_q <= 1'b1;
            state <= S_FIN;
          end
        end
        S_SEL: if (cs_half) state <= S_POLL_OP;
        S_POLL_OP: if (sh_fin) begin
          launched <= 1'b0;
          state    <= S_POLL_RX;
        end
        S_POLL_RX: if (sh_fin) begin
          launched <= 1'b0;
          cs_q     <= 1'b1;
          if (!sh_rx[0]) begin
            gap_next <= S_WREN;
            state    <= S_GAP_HI;
          end else if (retries == RT_W'(POLL_MAX - 1)) begin
            err_q <= 1'b1;
            state <= S_FIN;
          end else begin
            retries  <= retries + 1'b1;
            gap_next <= S_POLL_OP;
            state    <= S_GAP_HI;
          end
        end
        S_GAP_HI: if (cs_half) begin
          cs_q  <= 1'b0;
          state <= S_GAP_LO;
        end
        S_GAP_LO: if (cs_half) state <= gap_next;
        S_WREN: if (sh_fin) begin
          launched <= 1'b0;
          cs_q     <= 1'b1;
          gap_next <= S_WCMD;
          state    <= S_GAP_HI;
        end
        S_WCMD: if (sh_fin) begin
          launched <= 1'b0;
          state    <= S_WADDR;
        end
        S_WADDR: if (sh_fin) begin
          launched <= 1'b0;
          state    <= S_WGET;
        end
        S_WGET: if (word_valid) begin
          word_q <= word_data;
          state  <= S_WDATA;
        end
        S_WDATA: if (sh_fin) begin
          launched  <= 1'b0;
          cur_off   <= cur_off + 1'b1;
          remaining <= remaining - 1'b1;
          if (remaining == CNT_W'(1) || last_of_page) begin
            cs_q  <= 1'b1;
            state <= S_ENDPG;
          end else begin
            state <= S_WGET;
          end
        end
        S_ENDPG: if (cs_half) begin
          if (remaining == '0) begin
            state <= S_FIN;
          end else begin
            cs_q    <= 1'b0;
            retries <= '0;
            state   <= S_SEL;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign word_ready = (state == S_WGET);
  assign done       = (state == S_FIN);
  assign err        = err_q;
  assign cs_n       = cs_q;
endmodule

// File: rtl/spi_eew_checker.sv
module spi_eew_checker
  import spi_eew_pkg::*;
#(
  parameter int DEV_WORDS = 256,
  parameter int OFS_W     = 8,
  parameter int CNT_W     = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [OFS_W-1:0] start_off,
  input logic [CNT_W-1:0] word_cnt,
  input logic             word_valid,
  input logic             word_ready,
  input logic             done,
  input logic             err,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             ev_idle,
  input logic             ev_poll_done,
  input logic [7:0]       ev_status
);
  logic bad_req;
  assign bad_req = start && ev_idle &&
                   !req_in_range(int'(start_off), int'(word_cnt), DEV_WORDS);

  a_r1_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |=> (done && err));
  a_r1_reject_pins: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |=> cs_n);
  a_r2_clock_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r2_data_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);
  a_r2_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  a_r3_busy_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_poll_done && ev_status[0]) |=> cs_n);
  a_r9_one_word_per_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> !word_ready);
  a_r9_ready_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> !cs_n);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind spi_eeprom_page_writer spi_eew_checker #(
  .DEV_WORDS(DEV_WORDS), .OFS_W(OFS_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_off(start_off),
  .word_cnt(word_cnt), .word_valid(word_valid), .word_ready(word_ready),
  .done(done), .err(err), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .ev_idle(ev_idle), .ev_poll_done(ev_poll_done), .ev_status(ev_status)
);

// File: tb/sim_spi_eeprom_page_writer.sv
`timescale 1ns/1ps
module sim_spi_eeprom_page_writer;
  localparam int DEV_WORDS = 256;
  localparam int ABITS     = 8;
  localparam int PAGE      = 16;
  localparam int HALF      = 2;
  localparam int PMAX      = 4;
  localparam int OFS_W     = 8;
  localparam int CNT_W     = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [OFS_W-1:0] start_off = '0;
  logic [CNT_W-1:0] word_cnt = '0;
  logic [15:0] word_data = '0;
  logic word_valid = 1'b0;
  logic word_ready, done, err, cs_n, sclk, mosi;
  logic miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_eeprom_page_writer #(
    .DEV_WORDS(DEV_WORDS), .ADDR_BITS(ABITS), .OPC_W(8), .PAGE_BYTES(PAGE),
    .HALF_DIV(HALF), .POLL_MAX(PMAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_off(start_off),
    .word_cnt(word_cnt), .word_data(word_data), .word_valid(word_valid),
    .word_ready(word_ready), .done(done), .err(err), .cs_n(cs_n),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- device model: records frames, answers status reads
  logic [255:0] gq[$];
  int           gl[$];
  logic [255:0] fv;
  int           fn = 0;
  int           busy_left = 0;
  int           busy_cfg = 0;
  bit           stat_mode = 0;
  logic [7:0]   stat_v;
  int           stat_i = -1;
  logic         p_cs = 1'b1;
  logic         p_sk = 1'b0;

  always @(sclk or cs_n) begin
    if (cs_n !== p_cs) begin
      if (cs_n === 1'b0) begin
        fv = '0; fn = 0; stat_mode = 0; stat_i = -1;
      end else if (fn > 0) begin
        gq.push_back(fv); gl.push_back(fn);
        if (fv[255:248] == 8'h02 || fv[255:248] == 8'h0A) busy_left = busy_cfg;
        fn = 0;
      end
      p_cs = cs_n;
    end
    if (sclk !== p_sk) begin
      if (sclk === 1'b1 && cs_n === 1'b0) begin
        if (fn < 256) fv[255-fn] = mosi;
        fn++;
        if (fn == 8 && fv[255:248] == 8'h05) begin
          stat_mode = 1;
          stat_v = (busy_left > 0) ? 8'h8F : 8'hFE;   // only bit 0 matters
          if (busy_left > 0) busy_left--;
          stat_i = 7;
        end
      end else if (sclk === 1'b0 && cs_n === 1'b0 && stat_mode && stat_i >= 0) begin
        miso = stat_v[stat_i];
        stat_i--;
      end
      p_sk = sclk;
    end
  end

  // ---------------- word source
  logic [15:0] wfeed[$];
  bit          acc = 0;
  bit          stall_en = 0;
  int          stall_ctr = 0;

  always @(posedge clk) acc <= word_valid && word_ready;

  always @(negedge clk) begin
    if (acc && wfeed.size() > 0) void'(wfeed.pop_front());
    stall_ctr++;
    if (wfeed.size() > 0 && !(stall_en && (stall_ctr % 7) < 4)) begin
      word_valid = 1'b1;
      word_data  = wfeed[0];
    end else begin
      word_valid = 1'b0;
    end
  end

  // ---------------- per-clock monitor of pin rules
  int   mon_bad = 0;
  logic p_done = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (cs_n && (sclk || mosi)) mon_bad++;      // R2
    if (word_ready && cs_n) mon_bad++;           // R9
    if (p_done && done) mon_bad++;               // R10
    p_done = done;
  end

  // ---------------- expected frames
  logic [255:0] eq[$];
  int           el[$];
  logic [255:0] ev;
  int           en;

  task automatic put(input logic [15:0] v, input int n);
    for (int j = n - 1; j >= 0; j--) begin
      ev[255-en] = v[j];
      en++;
    end
  endtask

  task automatic close_f();
    eq.push_back(ev); el.push_back(en); ev = '0; en = 0;
  endtask

  task automatic plan(input int off, input int cnt, input int busy, output bit exp_err);
    int o;
    int left;
    logic [15:0] w;
    o = off; left = cnt; exp_err = 0; ev = '0; en = 0;
    while (left > 0 && !exp_err) begin
      for (int p = 0; p < ((busy < PMAX) ? busy : PMAX); p++) begin
        put(16'h05, 8); put(16'h00, 8); close_f();       // R3 busy poll
      end
      if (busy >= PMAX) exp_err = 1;                     // R4
      else begin
        put(16'h05, 8); put(16'h00, 8); close_f();       // R3 ready poll
        put(16'h06, 8); close_f();                       // R5
        put((o >= 128) ? 16'h0A : 16'h02, 8);            // R6
        put(16'((2 * o) % 256), ABITS);
        do begin
          w = 16'hC35A ^ 16'(o * 16'h0907);
          wfeed.push_back(w);
          put({w[7:0], w[15:8]}, 16);                    // R7
          o++; left--;
        end while (left > 0 && ((2 * o) % PAGE) != 0);   // R8
        close_f();
      end
    end
  endtask

  task automatic run(input string tag, input int off, input int cnt, input int busy,
                     input bit force_err);
    bit exp_err;
    int waited;
    gq.delete(); gl.delete(); eq.delete(); el.delete(); wfeed.delete();
    mon_bad = 0;
    busy_cfg = busy; busy_left = busy;
    if (force_err) exp_err = 1; else plan(off, cnt, busy, exp_err);
    @(negedge clk);
    start = 1'b1; start_off = OFS_W'(off); word_cnt = CNT_W'(cnt);
    waited = 0;
    @(negedge clk);
    start = 1'b0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    chk(done === 1'b1, tag, "done reached", 256'(done), 256'(1));
    chk(err === exp_err, tag, "err flag", 256'(err), 256'(exp_err));
    if (force_err) chk(waited == 0, "R1", "reject latency", 256'(waited), 256'(0));
    chk(gq.size() == eq.size(), tag, "frame count", 256'(gq.size()), 256'(eq.size()));
    for (int k = 0; k < eq.size() && k < gq.size(); k++) begin
      chk(gl[k] == el[k], tag, $sformatf("frame %0d length", k), 256'(gl[k]), 256'(el[k]));
      chk(gq[k] == eq[k], tag, $sformatf("frame %0d bits", k), gq[k], eq[k]);
    end
    chk(wfeed.size() == 0, "R9", {tag, " words consumed"}, 256'(wfeed.size()), 256'(0));
    @(negedge clk);
    chk(mon_bad == 0, "R2", {tag, " per-clock pin rules"}, 256'(mon_bad), 256'(0));
    chk(done === 1'b0, "R10", {tag, " done single cycle"}, 256'(done), 256'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R2", "reset pins",
        256'({cs_n, sclk, mosi}), 256'(3'b100));
    chk(done === 1'b0 && word_ready === 1'b0, "R10", "reset outputs",
        256'({done, word_ready}), 256'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run("R1", 250, 7, 0, 1);          // overruns device end
    run("R1", 0, 0, 0, 1);            // zero count
    run("R1", 0, 257, 0, 1);          // count larger than device
    run("R7", 3, 1, 0, 0);            // single word, ready at once
    run("R8", 5, 6, 2, 0);            // crosses a page, busy polls
    stall_en = 1;
    run("R9", 9, 10, 1, 0);           // stalled word source over two pages
    stall_en = 0;
    run("R6", 130, 2, 0, 0);          // ninth address bit in opcode
    run("R5", 248, 8, 3, 0);          // upper edge, full page
    run("R4", 20, 4, 10, 0);          // device stays busy
    run("R3", 100, 3, PMAX - 1, 0);   // ready on the last allowed poll

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule